// File: doc/BRIEF.md
# Multi-Mode Output Compare Channel

This block is a single compare channel that sits beside a free-running timer counter. Each clock it compares the counter value it is given against its active compare register and, according to a 3-bit mode field, drives an internal reference level. The reference can be held, set, cleared or toggled on an exact match, forced to a fixed level, or produced as a pulse-width waveform whose comparison rule depends on whether the counter is counting up or down.

Software writes the compare value through a write strobe. With buffering off the new value is used from the next clock. With buffering on it is parked in a shadow register and moves into the active register only on the timer's update pulse. An output stage applies an enable gate and a polarity inversion to the reference before it reaches the pin. A sticky flag records every match whatever the mode.

Top module: `cmp_out_channel`

## Requirements
- R1: Reset (synchronous, active high) clears the reference, the pin output, the match flag, the active compare value and the shadow value to 0.
- R2: With preload_en = 0, a value written with cmp_wr is the active compare value from the next clock edge, so a match against it can occur in the cycle after the write.
- R3: With preload_en = 1, cmp_wr only loads the shadow value; the active compare value changes only at an edge where upd_evt = 1, taking the shadow value held before that edge.
- R4: Mode 3'd0 (frozen) keeps the reference unchanged, match or not.
- R5: Mode 3'd1 sets the reference to 1 at an edge where counter equals active compare, and mode 3'd2 clears it to 0 on that equality; otherwise both hold it.
- R6: Mode 3'd3 inverts the reference at each edge where counter equals active compare.
- R7: Mode 3'd4 drives the reference to 0 and mode 3'd5 drives it to 1 at every edge.
- R8: Mode 3'd6: with cnt_down = 0 the reference becomes 1 when counter < compare and 0 otherwise; with cnt_down = 1 it becomes 0 when counter > compare and 1 otherwise.
- R9: Mode 3'd7 produces the complement of mode 3'd6 for both count directions.
- R10: The pin output registers (reference XOR out_pol) when out_en = 1 and the value out_pol (inactive level 0 after inversion) when out_en = 0; it changes on the same edge as the reference.
- R11: The match flag becomes 1 at any edge where counter equals active compare, in any mode; it returns to 0 only at an edge where flag_clr = 1 and no match occurs (a match wins over a clear).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | CW | Current timer counter value |
| cnt_down | input | 1 | Count direction, 1 = down-counting |
| upd_evt | input | 1 | Timer update pulse, one cycle |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | CW | Compare value to write |
| mode_sel | input | 3 | Reference behaviour selector |
| preload_en | input | 1 | Buffer compare writes until update pulse |
| out_en | input | 1 | Let the reference reach the pin |
| out_pol | input | 1 | Pin polarity, 1 = active low |
| flag_clr | input | 1 | Write-one-to-clear of the match flag |
| ref_o | output | 1 | Internal reference level |
| pin_o | output | 1 | Pin output after enable and polarity |
| match_flag_o | output | 1 | Sticky compare-match flag |

## Verification
The assertions assume every input is a known value at each rising edge once reset is released, and that the counter, direction and mode seen at an edge are the ones the result of that edge is judged against. The stimulus meets this by changing inputs only on the falling edge and holding them through the next rising edge. Write strobes and update pulses are never issued together while buffering is on, so the shadow hand-off is always between a settled shadow and the active register. Every mode is swept over a full small counter range in both directions, which stays inside the counter width with no wrap.

// File: rtl/cmpch_pkg.sv
package cmpch_pkg;

  typedef enum logic [2:0] {
    OCM_FROZEN = 3'd0,
    OCM_SET    = 3'd1,
    OCM_CLR    = 3'd2,
    OCM_TOG    = 3'd3,
    OCM_LOW    = 3'd4,
    OCM_HIGH   = 3'd5,
    OCM_PWM_A  = 3'd6,
    OCM_PWM_B  = 3'd7
  } ocm_e;

  localparam int unsigned OCM_BITS = 3;

endpackage

// File: rtl/cmpch_value.sv
module cmpch_value #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  input  logic          preload_en,
  input  logic          upd_evt,
  output logic [CW-1:0] active_o
);

  logic [CW-1:0] shadow_q;
  logic [CW-1:0] active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (wr) shadow_q <= wdata;
      if (!preload_en) begin
        if (wr) active_q <= wdata;
      end else if (upd_evt) begin
        active_q <= shadow_q;
      end
    end
  end

  assign active_o = active_q;

  // R2: unbuffered write reaches the active register one edge later
  p_direct_write_r2: assert property (@(posedge clk) disable iff (rst)
    (!preload_en && wr) |=> (active_o == $past(wdata)));

  // R3: buffered mode never moves the active value without an update pulse
  p_hold_until_update_r3: assert property (@(posedge clk) disable iff (rst)
    (preload_en && !upd_evt) |=> $stable(active_o));

endmodule

// File: rtl/cmpch_ref.sv
module cmpch_ref
  import cmpch_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [OCM_BITS-1:0] mode,
  input  logic [CW-1:0]       cnt,
  input  logic                down,
  input  logic [CW-1:0]       cmp,
  input  logic                flag_clr,
  output logic                ref_next_o,
  output logic                ref_o,
  output logic                flag_o
);

  logic ref_q, flag_q;
  logic hit, below, above, pwm_lvl;
  ocm_e m;

  always_comb begin
    m       = ocm_e'(mode);
    hit     = (cnt == cmp);
    below   = (cnt < cmp);
    above   = (cnt > cmp);
    pwm_lvl = down ? !above : below;
    case (m)
      OCM_FROZEN: ref_next_o = ref_q;
      OCM_SET:    ref_next_o = hit ? 1'b1 : ref_q;
      OCM_CLR:    ref_next_o = hit ? 1'b0 : ref_q;
      OCM_TOG:    ref_next_o = hit ? !ref_q : ref_q;
      OCM_LOW:    ref_next_o = 1'b0;
      OCM_HIGH:   ref_next_o = 1'b1;
      OCM_PWM_A:  ref_next_o = pwm_lvl;
      OCM_PWM_B:  ref_next_o = !pwm_lvl;
      default:    ref_next_o = ref_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      ref_q <= ref_next_o;
      if (hit)           flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  assign ref_o  = ref_q;
  assign flag_o = flag_q;

  // R4: frozen mode leaves the reference alone
  p_frozen_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == OCM_FROZEN) |=> $stable(ref_o));

  // R6: toggle on equality flips the level
  p_toggle_flip_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == OCM_TOG && cnt == cmp) |=> (ref_o != $past(ref_o)));

  // R7: forced high
  p_force_high_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == OCM_HIGH) |=> ref_o);

  // R8: first PWM form, up-counting below compare is active
  p_pwm_up_r8: assert property (@(posedge clk) disable iff (rst)
    (mode == OCM_PWM_A && !down && cnt < cmp) |=> ref_o);

  // R9: second PWM form is inactive in the same situation
  p_pwm_inv_r9: assert property (@(posedge clk) disable iff (rst)
    (mode == OCM_PWM_B && !down && cnt < cmp) |=> !ref_o);

  // R11: any equality leaves the flag set
  p_flag_set_r11: assert property (@(posedge clk) disable iff (rst)
    (cnt == cmp) |=> flag_o);

endmodule

// File: rtl/cmpch_drive.sv
module cmpch_drive (
  input  logic clk,
  input  logic rst,
  input  logic ref_next,
  input  logic out_en,
  input  logic out_pol,
  output logic pin_o
);

  logic pin_q;

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= out_en ? (ref_next ^ out_pol) : out_pol;
  end

  assign pin_o = pin_q;

  // R10: a disabled output sits at the inactive level after polarity
  p_disabled_level_r10: assert property (@(posedge clk) disable iff (rst)
    (!out_en) |=> (pin_o == $past(out_pol)));

endmodule

// File: rtl/cmp_out_channel.sv
module cmp_out_channel
  import cmpch_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_val,
  input  logic          cnt_down,
  input  logic          upd_evt,
  input  logic          cmp_wr,
  input  logic [CW-1:0] cmp_wdata,
  input  logic [2:0]    mode_sel,
  input  logic          preload_en,
  input  logic          out_en,
  input  logic          out_pol,
  input  logic          flag_clr,
  output logic          ref_o,
  output logic          pin_o,
  output logic          match_flag_o
);

  logic [CW-1:0] cmp_active;
  logic          ref_next;

  cmpch_value #(.CW(CW)) u_value (
    .clk        (clk),
    .rst        (rst),
    .wr         (cmp_wr),
    .wdata      (cmp_wdata),
    .preload_en (preload_en),
    .upd_evt    (upd_evt),
    .active_o   (cmp_active)
  );

  cmpch_ref #(.CW(CW)) u_ref (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode_sel),
    .cnt        (cnt_val),
    .down       (cnt_down),
    .cmp        (cmp_active),
    .flag_clr   (flag_clr),
    .ref_next_o (ref_next),
    .ref_o      (ref_o),
    .flag_o     (match_flag_o)
  );

  cmpch_drive u_drive (
    .clk      (clk),
    .rst      (rst),
    .ref_next (ref_next),
    .out_en   (out_en),
    .out_pol  (out_pol),
    .pin_o    (pin_o)
  );

  // R10: enabled pin tracks the reference through the polarity bit
  p_pin_follows_r10: assert property (@(posedge clk) disable iff (rst)
    (out_en) |=> (pin_o == (ref_o ^ $past(out_pol))));

  // R1: flag is clear on the first cycle after reset with no prior match
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!ref_o && !pin_o && !match_flag_o));

endmodule

// File: tb/test_cmp_out_channel.sv
module test_cmp_out_channel;
  localparam int CLK_P = 10;
  localparam int CW    = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] cnt_val = '0;
  logic cnt_down = 1'b0, upd_evt = 1'b0, cmp_wr = 1'b0;
  logic [CW-1:0] cmp_wdata = '0;
  logic [2:0] mode_sel = 3'd0;
  logic preload_en = 1'b0, out_en = 1'b0, out_pol = 1'b0, flag_clr = 1'b0;
  logic ref_o, pin_o, match_flag_o;

  int total = 0;
  int bad = 0;
  string tag_s = "R1";

  logic          ref_m = 1'b0, pin_m = 1'b0, flag_m = 1'b0;
  logic [CW-1:0] cmp_m = '0, shd_m = '0;

  always #(CLK_P/2) clk = ~clk;

  cmp_out_channel #(.CW(CW)) i_cmp_out_channel (
    .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_down(cnt_down),
    .upd_evt(upd_evt), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .mode_sel(mode_sel), .preload_en(preload_en), .out_en(out_en),
    .out_pol(out_pol), .flag_clr(flag_clr), .ref_o(ref_o), .pin_o(pin_o),
    .match_flag_o(match_flag_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b (mode=%0d cnt=%0d down=%b)",
               req, act, exp, mode_sel, cnt_val, cnt_down);
    end
  endtask

  // One clock: compute expected state from the requirements, then compare.
  task automatic tick();
    logic eq;
    logic r;
    logic [CW-1:0] c_n, s_n;
    eq = (cnt_val == cmp_m);
    case (mode_sel)
      3'd0: r = ref_m;
      3'd1: r = eq ? 1'b1 : ref_m;
      3'd2: r = eq ? 1'b0 : ref_m;
      3'd3: r = eq ? !ref_m : ref_m;
      3'd4: r = 1'b0;
      3'd5: r = 1'b1;
      3'd6: r = cnt_down ? (cnt_val <= cmp_m) : (cnt_val < cmp_m);
      default: r = cnt_down ? (cnt_val > cmp_m) : (cnt_val >= cmp_m);
    endcase
    c_n = cmp_m;
    s_n = cmp_wr ? cmp_wdata : shd_m;
    if (!preload_en && cmp_wr) c_n = cmp_wdata;
    else if (preload_en && upd_evt) c_n = shd_m;
    @(posedge clk);
    #1;
    flag_m = eq ? 1'b1 : (flag_clr ? 1'b0 : flag_m);
    pin_m  = out_en ? (r ^ out_pol) : out_pol;
    ref_m  = r;
    cmp_m  = c_n;
    shd_m  = s_n;
    check(tag_s, ref_o, ref_m);
    check("R10", pin_o, pin_m);
    check("R11", match_flag_o, flag_m);
    @(negedge clk);
    cmp_wr = 1'b0; upd_evt = 1'b0; flag_clr = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    check("R1", ref_o, 1'b0);
    check("R1", pin_o, 1'b0);
    check("R1", match_flag_o, 1'b0);

    // R2: unbuffered write, used one edge later
    tag_s = "R2";
    out_en = 1'b1; mode_sel = 3'd4; cnt_val = 16'd3;
    tick();
    mode_sel = 3'd1; cmp_wr = 1'b1; cmp_wdata = 16'd7; cnt_val = 16'd7;
    tick();
    tick();
    check("R2", ref_o, 1'b1);

    // R3: buffered write waits for the update pulse
    tag_s = "R3";
    mode_sel = 3'd4; tick();
    preload_en = 1'b1; mode_sel = 3'd1; cmp_wr = 1'b1; cmp_wdata = 16'd9;
    cnt_val = 16'd2; tick();
    cnt_val = 16'd9; tick(); tick();
    check("R3", ref_o, 1'b0);
    upd_evt = 1'b1; cnt_val = 16'd2; tick();
    cnt_val = 16'd9; tick();
    check("R3", ref_o, 1'b1);
    preload_en = 1'b0;

    // Mode sweeps: every mode, both directions, counter 0..15
    cmp_wr = 1'b1; cmp_wdata = 16'd5; mode_sel = 3'd4; tick();
    for (int md = 0; md < 8; md++) begin
      case (md)
        0: tag_s = "R4";
        1, 2: tag_s = "R5";
        3: tag_s = "R6";
        4, 5: tag_s = "R7";
        6: tag_s = "R8";
        default: tag_s = "R9";
      endcase
      for (int dn = 0; dn < 2; dn++) begin
        mode_sel = md[2:0];
        cnt_down = dn[0];
        out_pol = md[0] ^ dn[0];
        for (int k = 0; k < 16; k++) begin
          cnt_val = dn[0] ? CW'(15 - k) : CW'(k);
          tick();
        end
      end
    end
    cnt_down = 1'b0;

    // R10: enable and polarity combinations on both reference levels
    tag_s = "R10";
    for (int cmb = 0; cmb < 8; cmb++) begin
      mode_sel = cmb[0] ? 3'd5 : 3'd4;
      out_en = cmb[1];
      out_pol = cmb[2];
      cnt_val = 16'd1;
      tick();
    end
    out_en = 1'b1; out_pol = 1'b0;

    // R11: clear without match, then clear during match
    tag_s = "R11";
    mode_sel = 3'd0; cnt_val = 16'd5; tick();
    check("R11", match_flag_o, 1'b1);
    cnt_val = 16'd3; flag_clr = 1'b1; tick();
    check("R11", match_flag_o, 1'b0);
    tick();
    check("R11", match_flag_o, 1'b0);
    cnt_val = 16'd5; flag_clr = 1'b1; tick();
    check("R11", match_flag_o, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule